// File: doc/BRIEF.md
# Configurable Slice Storage Element Group

This block models eight storage elements that share one logic site and take their behaviour from a static configuration word. Elements 0 to 3 sit at full-LUT positions and elements 4 to 7 at half-LUT positions. Several settings apply to the whole site: a mode bit chooses between edge-triggered flip-flops and level-sensitive latches, a second bit chooses synchronous or immediate set/reset, and a third bit sets the polarity of the shared clock or gate. Each element also carries its own reset-value bit and its own power-up value bit.

All elements share one clock/gate, one clock enable, one set/reset pin and one active-low global initialisation input. Two usage selects decide whether the enable and set/reset pins are honoured or tied off. The configuration word may only change while global initialisation is held low. Global initialisation outranks set/reset, and set/reset outranks the enable.

Top module: `slice_stor_group`

## Requirements
- R1: With the latch bit cfg[0]=0 and the clock-inversion bit cfg[2]=0, every element is a flip-flop that captures d on the rising clk edge (when enabled) and ignores the falling edge.
- R2: With cfg[0]=0 and cfg[2]=1, every element captures d on the falling clk edge and ignores the rising edge.
- R3: With cfg[0]=1, elements 0..3 (q[3:0]) act as latches and elements 4..7 (q[7:4]) always read 0.
- R4: In latch mode, cfg[2]=0 makes the latches transparent while clk is low, and cfg[2]=1 makes them transparent while clk is high. They hold their value while the gate is closed.
- R5: With the enable-usage bit cfg[3]=0 the elements are always enabled and ce is ignored. With cfg[3]=1 they load only while ce=1, and otherwise hold. In latch mode ce is the gate enable.
- R6: With the set/reset-usage bit cfg[4]=0 the sr pin has no effect. With cfg[4]=1, sr=1 applies the reset value.
- R7: The reset-value bit for element i is cfg[5+i]. When it is 1, reset loads 0. When it is 0, reset loads 1.
- R8: In flip-flop mode with the sync bit cfg[1]=1, set/reset takes effect only at the capture edge, and it does so even when the enable is low.
- R9: In flip-flop mode with cfg[1]=0, set/reset forces the reset value at once, without waiting for a clock edge. In latch mode set/reset always acts at once, whatever cfg[1] holds.
- R10: While init_n=0, flip-flops load the inverse of their power-up bit cfg[13+i] at the capture edge. Latches load cfg[13+i] directly and at once.
- R11: Global initialisation takes priority over set/reset. While init_n=0 with sr=1, the elements hold their power-up value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock (flip-flop mode) or gate (latch mode) |
| init_n | input | 1 | Active-low global initialisation; loads power-up values |
| ce | input | 1 | Shared clock/gate enable |
| sr | input | 1 | Shared set/reset request |
| d | input | 8 | Per-element data |
| cfg | input | 21 | Static configuration word (field positions in R1-R11 text) |
| q | output | 8 | Per-element stored value |

## Verification
The assertions assume that the configuration word changes only while init_n is low, and that init_n stays low across at least one capture edge before it is released. The bench follows this: it drops init_n before it writes a new word and holds it low for two full clock periods. The edge-based properties also assume that ce, sr and d never move on the same timestep as a clk edge. The bench therefore drives every input one or more nanoseconds after a clock transition. The assertions for immediate set/reset assume that sr is released before init_n rises. The priority test obeys this ordering.

// File: rtl/slice_stor_pkg.sv
`timescale 1ns/1ps
// Package: shared field positions and the site-wide mode type for the
// slice storage group. Assumes the five site-wide control bits sit at the
// bottom of the configuration word, followed by the per-element fields.
package slice_stor_pkg;

    localparam int CTRL_W = 5;

    // Site-wide control bits; bit 0 is the latch mode select.
    typedef struct packed {
        logic sr_used;
        logic ce_used;
        logic clk_inv;
        logic sync_rst;
        logic latch_mode;
    } slice_mode_t;

    // Width of the whole configuration word for a given element count.
    function automatic int cfg_width(input int n_elem);
        return CTRL_W + 2 * n_elem;
    endfunction

endpackage

// File: rtl/slice_stor_decode.sv
`timescale 1ns/1ps
// Module: slice_stor_decode
// Turns the static configuration word plus the shared control pins into
// effective enable, set/reset and load values. It assumes cfg changes only
// while init_n is low. The immediate reset request is gated off while
// init_n is low, so global initialisation wins over set/reset.
module slice_stor_decode
    import slice_stor_pkg::*;
#(
    parameter int N_ELEM = 8,
    parameter int N_FULL = 4,
    localparam int CFG_W = cfg_width(N_ELEM),
    localparam int RV_LSB = CTRL_W,
    localparam int IV_LSB = CTRL_W + N_ELEM
) (
    input  logic [CFG_W-1:0]  cfg,
    input  logic              ce,
    input  logic              sr,
    input  logic              init_n,
    output slice_mode_t       mode,
    output logic              ce_eff,
    output logic              sr_eff,
    output logic              arst,
    output logic [N_ELEM-1:0] rst_val,
    output logic [N_ELEM-1:0] ff_init,
    output logic [N_FULL-1:0] lat_init
);

    logic [N_ELEM-1:0] rv_bits;
    logic [N_ELEM-1:0] iv_bits;

    assign mode    = slice_mode_t'(cfg[CTRL_W-1:0]);
    assign rv_bits = cfg[RV_LSB +: N_ELEM];
    assign iv_bits = cfg[IV_LSB +: N_ELEM];

    // Effective control: tie-offs, then the immediate-reset request.
    always_comb begin
        ce_eff = !mode.ce_used || ce;
        sr_eff = mode.sr_used && sr;
        arst   = sr_eff && !mode.sync_rst && !mode.latch_mode && init_n;
    end

    // Per-element load values: the reset bit is active-low, and the
    // power-up bit is inverted for flip-flops but direct for latches.
    always_comb begin
        rst_val  = ~rv_bits;
        ff_init  = ~iv_bits;
        lat_init = iv_bits[N_FULL-1:0];
    end

endmodule

// File: rtl/slice_stor_ffbank.sv
`timescale 1ns/1ps
// Module: slice_stor_ffbank
// A bank of N flip-flops with one capture edge, fixed by NEG_EDGE. Two
// banks with opposite edges let the site pick its polarity without any
// gating on the clock. It assumes arst comes from decode logic, and that
// it can be high only while init_n is high and synchronous mode is off.
module slice_stor_ffbank #(
    parameter int N        = 8,
    parameter bit NEG_EDGE = 1'b0
) (
    input  logic         clk,
    input  logic         init_n,
    input  logic         arst,
    input  logic         sync_rst,
    input  logic         sr_eff,
    input  logic         ce_eff,
    input  logic [N-1:0] d,
    input  logic [N-1:0] rst_val,
    input  logic [N-1:0] init_val,
    output logic [N-1:0] q
);

    logic [N-1:0] q_r;

    assign q = q_r;

    if (NEG_EDGE) begin : g_neg
        // Falling-edge storage: immediate reset, init, edge reset, load.
        always_ff @(negedge clk or posedge arst) begin
            if (arst)                    q_r <= rst_val;
            else if (!init_n)            q_r <= init_val;
            else if (sync_rst && sr_eff) q_r <= rst_val;
            else if (ce_eff)             q_r <= d;
        end

        a_r5_ce_hold_neg: assert property (@(negedge clk) disable iff (!init_n)
            (sync_rst && !sr_eff && !ce_eff) |=> $stable(q_r));
        a_r8_sync_sr_neg: assert property (@(negedge clk) disable iff (!init_n)
            (sync_rst && sr_eff) |=> (q_r == rst_val));
        a_r9_async_sr_neg: assert property (@(negedge clk) disable iff (!init_n)
            arst |-> (q_r == rst_val));
    end else begin : g_pos
        // Rising-edge storage: immediate reset, init, edge reset, load.
        always_ff @(posedge clk or posedge arst) begin
            if (arst)                    q_r <= rst_val;
            else if (!init_n)            q_r <= init_val;
            else if (sync_rst && sr_eff) q_r <= rst_val;
            else if (ce_eff)             q_r <= d;
        end

        a_r5_ce_hold_pos: assert property (@(posedge clk) disable iff (!init_n)
            (sync_rst && !sr_eff && !ce_eff) |=> $stable(q_r));
        a_r8_sync_sr_pos: assert property (@(posedge clk) disable iff (!init_n)
            (sync_rst && sr_eff) |=> (q_r == rst_val));
        a_r9_async_sr_pos: assert property (@(posedge clk) disable iff (!init_n)
            arst |-> (q_r == rst_val));
    end

endmodule

// File: rtl/slice_stor_latchbank.sv
`timescale 1ns/1ps
// Module: slice_stor_latchbank
// Level-sensitive storage for the full-LUT positions. Its priority is
// init (direct value), then set/reset (always immediate), then load while
// the gate is open and enabled. gate_high picks the transparent level.
// It assumes the configuration is static while init_n is high.
module slice_stor_latchbank #(
    parameter int N = 4
) (
    input  logic         gate,
    input  logic         gate_high,
    input  logic         init_n,
    input  logic         sr_eff,
    input  logic         ce_eff,
    input  logic [N-1:0] d,
    input  logic [N-1:0] rst_val,
    input  logic [N-1:0] init_val,
    output logic [N-1:0] q
);

    logic         open_w;
    logic [N-1:0] lq;

    // Transparent level: high gate when gate_high is set, else low gate.
    assign open_w = gate_high ? gate : !gate;
    assign q      = lq;

    // Level-sensitive storage with init over set/reset over load.
    always_latch begin
        if (!init_n)               lq = init_val;
        else if (sr_eff)           lq = rst_val;
        else if (open_w && ce_eff) lq = d;
    end

    a_r9_latch_sr: assert property (@(posedge gate) disable iff (!init_n)
        sr_eff |-> (lq == rst_val));

endmodule

// File: rtl/slice_stor_group.sv
`timescale 1ns/1ps
// Module: slice_stor_group (top)
// Eight configurable storage elements that share one site. Two flip-flop
// banks, one per edge, plus a latch bank for the full-LUT positions feed
// an output select driven by the mode bits. It assumes cfg is static
// except while init_n is low.
module slice_stor_group
    import slice_stor_pkg::*;
#(
    parameter int N_FULL = 4,
    parameter int N_HALF = 4,
    localparam int N_ELEM = N_FULL + N_HALF,
    localparam int CFG_W = cfg_width(N_ELEM)
) (
    input  logic              clk,
    input  logic              init_n,
    input  logic              ce,
    input  logic              sr,
    input  logic [N_ELEM-1:0] d,
    input  logic [CFG_W-1:0]  cfg,
    output logic [N_ELEM-1:0] q
);

    slice_mode_t       mode;
    logic              ce_eff;
    logic              sr_eff;
    logic              arst;
    logic [N_ELEM-1:0] rst_val;
    logic [N_ELEM-1:0] ff_init;
    logic [N_FULL-1:0] lat_init;
    logic [N_ELEM-1:0] q_pos;
    logic [N_ELEM-1:0] q_neg;
    logic [N_FULL-1:0] q_lat;

    slice_stor_decode #(.N_ELEM(N_ELEM), .N_FULL(N_FULL)) u_decode (
        .cfg      (cfg),
        .ce       (ce),
        .sr       (sr),
        .init_n   (init_n),
        .mode     (mode),
        .ce_eff   (ce_eff),
        .sr_eff   (sr_eff),
        .arst     (arst),
        .rst_val  (rst_val),
        .ff_init  (ff_init),
        .lat_init (lat_init)
    );

    slice_stor_ffbank #(.N(N_ELEM), .NEG_EDGE(1'b0)) u_ff_pos (
        .clk      (clk),
        .init_n   (init_n),
        .arst     (arst),
        .sync_rst (mode.sync_rst),
        .sr_eff   (sr_eff),
        .ce_eff   (ce_eff),
        .d        (d),
        .rst_val  (rst_val),
        .init_val (ff_init),
        .q        (q_pos)
    );

    slice_stor_ffbank #(.N(N_ELEM), .NEG_EDGE(1'b1)) u_ff_neg (
        .clk      (clk),
        .init_n   (init_n),
        .arst     (arst),
        .sync_rst (mode.sync_rst),
        .sr_eff   (sr_eff),
        .ce_eff   (ce_eff),
        .d        (d),
        .rst_val  (rst_val),
        .init_val (ff_init),
        .q        (q_neg)
    );

    slice_stor_latchbank #(.N(N_FULL)) u_latch (
        .gate      (clk),
        .gate_high (mode.clk_inv),
        .init_n    (init_n),
        .sr_eff    (sr_eff),
        .ce_eff    (ce_eff),
        .d         (d[N_FULL-1:0]),
        .rst_val   (rst_val[N_FULL-1:0]),
        .init_val  (lat_init),
        .q         (q_lat)
    );

    // Output select: latches with half positions tied low, or the bank
    // that matches the chosen flip-flop edge.
    always_comb begin
        if (mode.latch_mode)   q = {{N_HALF{1'b0}}, q_lat};
        else if (mode.clk_inv) q = q_neg;
        else                   q = q_pos;
    end

endmodule

// File: tb/slice_stor_group_bench.sv
`timescale 1ns/1ps
module slice_stor_group_bench;

    logic        clk = 1'b0;
    logic        init_n = 1'b0;
    logic        ce = 1'b0;
    logic        sr = 1'b0;
    logic [7:0]  d = '0;
    logic [20:0] cfg = '0;
    logic [7:0]  q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    slice_stor_group u_slice_stor_group (
        .clk(clk), .init_n(init_n), .ce(ce), .sr(sr), .d(d), .cfg(cfg), .q(q)
    );

    always #5 clk = ~clk;

    // mode bits m = {sr_used, ce_used, clk_inv, sync, latch}
    typedef struct packed {
        logic [4:0] m;
        logic [7:0] rb;
        logic [7:0] ib;
        logic [7:0] dd;
        logic       c;
        logic       s;
        logic [7:0] ei;
        logic [7:0] ea;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{5'b00000, 8'hA5, 8'h3C, 8'h96, 1'b0, 1'b1, 8'hC3, 8'h96}, // R5 R6 R10 tie-offs
        '{5'b11010, 8'hA5, 8'h3C, 8'h96, 1'b0, 1'b0, 8'hC3, 8'hC3}, // R5 hold
        '{5'b11010, 8'hA5, 8'h3C, 8'h69, 1'b1, 1'b0, 8'hC3, 8'h69}, // R1 load
        '{5'b11010, 8'hA5, 8'h3C, 8'h69, 1'b0, 1'b1, 8'hC3, 8'h5A}, // R8 R7 sr over ce
        '{5'b11110, 8'hA5, 8'h3C, 8'h0F, 1'b1, 1'b0, 8'hC3, 8'h0F}, // R2 falling edge
        '{5'b11000, 8'hA5, 8'h3C, 8'hFF, 1'b1, 1'b1, 8'hC3, 8'h5A}, // R9 async
        '{5'b11101, 8'hA5, 8'h3C, 8'hFF, 1'b1, 1'b0, 8'h0C, 8'h0F}, // R3 R10 latch
        '{5'b11001, 8'hA5, 8'h3C, 8'hFF, 1'b0, 1'b0, 8'h0C, 8'h0C}, // R5 latch gate enable
        '{5'b11001, 8'hA5, 8'h3C, 8'hFF, 1'b1, 1'b1, 8'h0C, 8'h0A}, // R9 latch sr
        '{5'b11011, 8'hA5, 8'h3C, 8'h00, 1'b0, 1'b1, 8'h0C, 8'h0A}, // R9 sync ignored in latch
        '{5'b11010, 8'h0F, 8'hF0, 8'h00, 1'b0, 1'b1, 8'h0F, 8'hF0}, // R7 R10 other bits
        '{5'b11101, 8'hA5, 8'h05, 8'h30, 1'b1, 1'b0, 8'h05, 8'h00}  // R3 half ignored
    };

    task automatic at_pos(input int off);
        @(posedge clk);
        #(off);
    endtask

    task automatic at_neg(input int off);
        @(negedge clk);
        #(off);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: q=%h expected %h", tag, act, exp);
        end
    endtask

    // Hold init low over two full periods while the word is changed.
    task automatic setup(input logic [4:0] m, input logic [7:0] rb, input logic [7:0] ib);
        init_n = 1'b0;
        ce = 1'b0;
        sr = 1'b0;
        d = '0;
        cfg = {ib, rb, m};
        at_pos(1);
        at_pos(1);
    endtask

    initial begin
        at_pos(1);
        for (int i = 0; i < 12; i++) begin
            setup(VEC[i].m, VEC[i].rb, VEC[i].ib);
            chk($sformatf("R10 init row %0d", i), q, VEC[i].ei);
            init_n = 1'b1;
            d = VEC[i].dd;
            ce = VEC[i].c;
            sr = VEC[i].s;
            at_pos(1);
            chk($sformatf("R1-group row %0d (R5 R6 R7)", i), q, VEC[i].ea);
        end

        // R9: immediate reset, before any edge
        setup(5'b11000, 8'hA5, 8'h3C);
        init_n = 1'b1; sr = 1'b1;
        #2 chk("R9 immediate sr", q, 8'h5A);
        sr = 1'b0;
        at_pos(1);
        chk("R9 held after release", q, 8'h5A);

        // R8: synchronous reset waits for the edge
        setup(5'b11010, 8'hA5, 8'h3C);
        init_n = 1'b1; sr = 1'b1;
        #2 chk("R8 no early reset", q, 8'hC3);
        at_pos(1);
        chk("R8 reset at edge", q, 8'h5A);

        // R2: falling-edge capture ignores the rising edge
        setup(5'b11110, 8'hA5, 8'h3C);
        init_n = 1'b1;
        at_neg(1);
        d = 8'h81; ce = 1'b1;
        at_pos(1);
        chk("R2 rising edge ignored", q, 8'hC3);
        at_neg(1);
        chk("R2 falling capture", q, 8'h81);

        // R1: rising-edge capture ignores the falling edge
        setup(5'b11010, 8'hA5, 8'h3C);
        init_n = 1'b1; ce = 1'b1; d = 8'h42;
        at_neg(1);
        chk("R1 falling edge ignored", q, 8'hC3);
        at_pos(1);
        chk("R1 rising capture", q, 8'h42);

        // R4: latch transparent while high (cfg[2]=1)
        setup(5'b11101, 8'hA5, 8'h3C);
        init_n = 1'b1;
        at_neg(1);
        d = 8'h07; ce = 1'b1;
        #2 chk("R4 opaque while low", q, 8'h0C);
        at_pos(1);
        chk("R4 transparent while high", q, 8'h07);

        // R4: latch transparent while low (cfg[2]=0)
        setup(5'b11001, 8'hA5, 8'h3C);
        init_n = 1'b1; ce = 1'b1; d = 8'h09;
        #2 chk("R4 opaque while high", q, 8'h0C);
        at_neg(1);
        chk("R4 transparent while low", q, 8'h09);

        // R11: global init beats set/reset
        setup(5'b11000, 8'hA5, 8'h3C);
        sr = 1'b1;
        at_pos(1);
        at_pos(1);
        chk("R11 init over sr", q, 8'hC3);
        sr = 1'b0;
        at_pos(1);
        init_n = 1'b1;
        at_pos(1);
        chk("R11 value kept after release", q, 8'hC3);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule